// File: doc/BRIEF.md
# Strobed Output Port Handshake

This block is one output channel of a programmable parallel interface working in its strobed-output mode. The processor writes a byte with an active-low write strobe; the byte is captured when the strobe returns high and is then held on the port pins for the peripheral. An active-low buffer-full line tells the peripheral that a fresh byte is waiting. The peripheral takes the byte and pulses an active-low acknowledge. That pulse frees the buffer. If the channel's interrupt enable is set, an interrupt request is then raised so the processor can send the next byte.

The interrupt enable is a single flag changed by a bit set/reset control write. In this command word, bit 7 is zero, bits 3:1 select a port C bit, and bit 0 gives the new value. The channel answers only to its own bit number, which is a parameter (6 for the A-side channel, 2 for the B-side channel). The acknowledge comes from the peripheral clock domain, so it passes through a synchronizer before its falling edge is detected. The write strobe and the control write are synchronous to the block clock.

Top module: `strobed_out_port`

## Requirements
- R1: On the first clock edge where `wrN` is sampled high after being sampled low, `portOut` takes the value of `busData` in that cycle. It then holds that value until the next such edge.
- R2: `obfN` goes low on that same write-rise edge, so it is low from the following cycle onward.
- R3: `ackN` passes through SYNC_STAGES flops (2 by default). `obfN` returns high SYNC_STAGES clock edges after the first edge that samples `ackN` low following a high level, which is 3 edges counting that first one. Holding `ackN` low has no further effect.
- R4: `intr` is set one edge after a cycle in which all of the following hold: the synchronized acknowledge is high, `obfN` is high, the enable flag is 1, and `wrN` was sampled high on this edge and on the previous edge.
- R5: An edge that samples `wrN` low after it was sampled high clears `intr`. `intr` stays low while `wrN` stays low.
- R6: A cycle with `ctlWr`=1, `busData[7]`=0 and `busData[3:1]`=INTE_BIT loads `busData[0]` into the enable flag. Commands with other bit numbers, or with `busData[7]`=1, change nothing. While the flag is 0, `intr` is driven low from the next edge.
- R7: A synchronous `rst` leaves `obfN` high, `intr` low, `portOut` zero and the enable flag cleared.
- R8: If a write rise and a detected acknowledge fall occur on the same edge, the write wins: `obfN` is low afterwards and `portOut` holds the new byte.
- R9: `intr` is never high while `obfN` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wrN | input | 1 | Processor write strobe for the port, active low, synchronous to clk |
| ctlWr | input | 1 | One-cycle control-word write; a bit set/reset command when busData[7] is 0 |
| busData | input | DATA_W | Processor data bus: byte for the port, or a control word |
| ackN | input | 1 | Peripheral acknowledge, active low, asynchronous |
| portOut | output | DATA_W | Latched byte driven to the peripheral |
| obfN | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request, active high |

## Verification
The embedded properties check the following on every cycle:
- `obfN` only falls after a write rise and only rises after a detected acknowledge fall.
- The write wins when both happen on the same edge.
- `intr` never rises without its four conditions.
- `intr` is cleared by a write start or a cleared enable, and is never high together with a pending byte.
- The latched byte only changes on a load strobe.

Only the bench scenarios can show the rest:
- the exact synchronizer latency from an acknowledge pin edge to `obfN`;
- which byte value is captured;
- that commands for other bits and mode words leave the enable flag untouched;
- the full reset state of the outputs.

// File: rtl/strobed_out_pkg.sv
package strobed_out_pkg;

  // Strobes from the control section to the byte datapath
  typedef struct packed {
    logic clrByte;   // return the latch to zero
    logic loadByte;  // capture the bus byte
  } dpStrobe_t;

  // Bit set/reset command word layout (8-bit control word)
  localparam int CMD_FLAG_BIT = 7;
  localparam int CMD_SEL_LSB  = 1;
  localparam int CMD_SEL_W    = 3;
  localparam int CMD_VAL_BIT  = 0;

endpackage

// File: rtl/strobed_out_sync.sv
module strobed_out_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fell
);

  logic [STAGES-1:0] chain;
  logic              lastLevel;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= IDLE;
    else     lastLevel <= level;
  end

  assign fell = lastLevel & ~level;

endmodule

// File: rtl/strobed_out_dp.sv
module strobed_out_dp
  import strobed_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] latchQ;

  always_ff @(posedge clk) begin
    if (strobes.clrByte)       latchQ <= '0;
    else if (strobes.loadByte) latchQ <= busData;
  end

  assign dataOut = latchQ;

  // R1
  byte_hold_chk: assert property (@(posedge clk) disable iff (strobes.clrByte)
    !strobes.loadByte |=> $stable(dataOut));

endmodule

// File: rtl/strobed_out_ctrl.sv
module strobed_out_ctrl
  import strobed_out_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INTE_BIT    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrN,
  input  logic                 ctlWr,
  input  logic                 cmdFlag,
  input  logic [CMD_SEL_W-1:0] cmdSel,
  input  logic                 cmdVal,
  input  logic                 ackN,
  output dpStrobe_t            strobes,
  output logic                 obfN,
  output logic                 intr
);

  localparam logic [CMD_SEL_W-1:0] INTE_SEL = INTE_BIT[CMD_SEL_W-1:0];

  logic wrPrev, wrRise, wrFall, wrSteady;
  logic ackLevel, ackFall;
  logic inte, bsrHit, intrSet;

  // Write strobe edges (strobe is already in this clock domain)
  always_ff @(posedge clk) begin
    if (rst) wrPrev <= 1'b1;
    else     wrPrev <= wrN;
  end

  assign wrRise   = wrN & ~wrPrev;
  assign wrFall   = ~wrN & wrPrev;
  assign wrSteady = wrN & wrPrev;

  // Acknowledge crosses from the peripheral domain
  strobed_out_sync #(
    .STAGES(SYNC_STAGES),
    .IDLE  (1'b1)
  ) ackSync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (ackN),
    .level(ackLevel),
    .fell (ackFall)
  );

  // Buffer-full flag: a new byte wins over a same-edge acknowledge
  always_ff @(posedge clk) begin
    if (rst)          obfN <= 1'b1;
    else if (wrRise)  obfN <= 1'b0;
    else if (ackFall) obfN <= 1'b1;
  end

  // Interrupt enable from the bit set/reset command
  assign bsrHit = ctlWr & ~cmdFlag & (cmdSel == INTE_SEL);

  always_ff @(posedge clk) begin
    if (rst)         inte <= 1'b0;
    else if (bsrHit) inte <= cmdVal;
  end

  // Interrupt request
  assign intrSet = ackLevel & obfN & inte & wrSteady;

  always_ff @(posedge clk) begin
    if (rst)                 intr <= 1'b0;
    else if (wrFall || !inte) intr <= 1'b0;
    else if (intrSet)        intr <= 1'b1;
  end

  always_comb begin
    strobes.clrByte  = rst;
    strobes.loadByte = wrRise;
  end

  // R2
  obf_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(obfN) |-> ($past(wrN) && !$past(wrN, 2)));

  // R3
  obf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(obfN) |-> $past(ackFall));

  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wrRise && ackFall) |=> !obfN);

  // R9
  intr_obf_chk: assert property (@(posedge clk) disable iff (rst)
    !obfN |-> !intr);

  // R5
  intr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wrFall |=> !intr);

  // R4
  intr_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr) |-> $past(inte && obfN && ackLevel && wrN));

  // R6
  inte_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !inte |=> !intr);

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (obfN && !intr && !inte));

endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import strobed_out_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INTE_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrN,
  input  logic              ctlWr,
  input  logic [DATA_W-1:0] busData,
  input  logic              ackN,
  output logic [DATA_W-1:0] portOut,
  output logic              obfN,
  output logic              intr
);

  dpStrobe_t strobes;

  strobed_out_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .INTE_BIT   (INTE_BIT)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wrN    (wrN),
    .ctlWr  (ctlWr),
    .cmdFlag(busData[CMD_FLAG_BIT]),
    .cmdSel (busData[CMD_SEL_LSB +: CMD_SEL_W]),
    .cmdVal (busData[CMD_VAL_BIT]),
    .ackN   (ackN),
    .strobes(strobes),
    .obfN   (obfN),
    .intr   (intr)
  );

  strobed_out_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .strobes(strobes),
    .busData(busData),
    .dataOut(portOut)
  );

endmodule

// File: tb/strobed_out_port_tb_top.sv
`timescale 1ns/100ps
module strobed_out_port_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrN = 1'b1;
  logic       ctlWr = 1'b0;
  logic [7:0] busData = 8'h00;
  logic       ackN = 1'b1;
  logic [7:0] portOut;
  logic       obfN;
  logic       intr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_out_port dut_i (
    .clk(clk), .rst(rst), .wrN(wrN), .ctlWr(ctlWr), .busData(busData),
    .ackN(ackN), .portOut(portOut), .obfN(obfN), .intr(intr)
  );

  // Behavioural reference model, advanced on every rising edge
  bit       ackHist[$];
  bit       mWrPrev = 1, mAckPrev = 1, mObfN = 1, mIntr = 0, mInte = 0;
  bit [7:0] mData = 0;

  always @(posedge clk) begin
    bit ackSeen, rise, fall, ackDrop, oldObf, oldInte;
    if (rst) begin
      ackHist = {1'b1, 1'b1};
      mWrPrev = 1; mAckPrev = 1; mObfN = 1; mIntr = 0; mInte = 0; mData = 0;
    end else begin
      ackSeen = ackHist[0];
      rise    = wrN && !mWrPrev;
      fall    = !wrN && mWrPrev;
      ackDrop = !ackSeen && mAckPrev;
      oldObf  = mObfN;
      oldInte = mInte;
      if (fall || !oldInte) mIntr = 0;
      else if (ackSeen && oldObf && oldInte && wrN && mWrPrev) mIntr = 1;
      if (rise) begin mObfN = 0; mData = busData; end
      else if (ackDrop) mObfN = 1;
      if (ctlWr && !busData[7] && busData[3:1] == 3'd6) mInte = busData[0];
      mWrPrev  = wrN;
      mAckPrev = ackSeen;
      void'(ackHist.pop_front());
      ackHist.push_back(ackN);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (portOut !== mData) begin
        errors++;
        $display("FAIL R1 portOut act=%h exp=%h at %0t", portOut, mData, $time);
      end
      checks++;
      if (obfN !== mObfN) begin
        errors++;
        $display("FAIL R2/R3/R8 obfN act=%b exp=%b at %0t", obfN, mObfN, $time);
      end
      checks++;
      if (intr !== mIntr) begin
        errors++;
        $display("FAIL R4/R5/R6 intr act=%b exp=%b at %0t", intr, mIntr, $time);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic ctlCmd(logic [7:0] w);
    ctlWr = 1'b1; busData = w;
    step();
    ctlWr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    // R7 reset state
    chk("R7 obfN", obfN, 1);
    chk("R7 intr", intr, 0);
    chk("R7 portOut", portOut, 0);
    // R6 enable still clear: no request though ack idle high
    step(3);
    chk("R6 intr with enable clear", intr, 0);
    // R6 set enable via bit 6 (0x0D), R4 request follows
    ctlCmd(8'h0D);
    step();
    chk("R4 intr after enable", intr, 1);
    // R5 write start clears request; R1/R2 capture on rise
    wrN = 1'b0; busData = 8'hA5;
    step();
    chk("R5 intr on write fall", intr, 0);
    step();
    chk("R5 intr while write low", intr, 0);
    wrN = 1'b1;
    step();
    chk("R1 portOut captured", portOut, 8'hA5);
    chk("R2 obfN low", obfN, 0);
    busData = 8'h3C;
    step();
    chk("R1 portOut held", portOut, 8'hA5);
    // R3 acknowledge through synchronizer
    ackN = 1'b0;
    step(2);
    chk("R3 obfN before sync latency", obfN, 0);
    step();
    chk("R3 obfN released", obfN, 1);
    step(2);
    chk("R4 no intr while ack low", intr, 0);
    ackN = 1'b1;
    step(4);
    chk("R4 intr after ack high", intr, 1);
    // R6 clear enable (0x0C)
    ctlCmd(8'h0C);
    step(2);
    chk("R6 intr dropped on clear", intr, 0);
    // R6 other bit and mode word are ignored
    ctlCmd(8'h0B);
    ctlCmd(8'h8D);
    step(3);
    chk("R6 ignored commands", intr, 0);
    // R8 write rise coincides with detected ack fall
    wrN = 1'b0; step();
    wrN = 1'b1; busData = 8'h11; step();
    step(2);
    chk("R2 obfN pending", obfN, 0);
    ackN = 1'b0; step();
    wrN = 1'b0; busData = 8'h77; step();
    wrN = 1'b1; step();
    chk("R8 obfN write wins", obfN, 0);
    chk("R8 portOut new byte", portOut, 8'h77);
    ackN = 1'b1;
    step(4);
    chk("R9 no intr while pending", intr, 0);
    // Random traffic checked against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 12) wrN = ~wrN;
      if ($urandom_range(0, 99) < 15) ackN = ~ackN;
      busData = 8'($urandom);
      ctlWr = 1'b0;
      if ($urandom_range(0, 99) < 4) begin
        ctlWr = 1'b1;
        case ($urandom_range(0, 4))
          0: busData = 8'h0D;
          1: busData = 8'h0C;
          2: busData = 8'h0B;
          3: busData = 8'h8D;
          default: busData = 8'($urandom);
        endcase
      end
      step();
    end
    ctlWr = 1'b0; wrN = 1'b1; ackN = 1'b1;
    step(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule